// File: doc/BRIEF.md
# Block Quantizer with Reciprocal Multiply and Early Skip

This block quantizes one 8x8 block of transform coefficients. The coefficients arrive in scan order, two per beat, so a block takes 32 beats. A divider would be slow, so each division by the quantizer scale is done another way. The block multiplies the coefficient magnitude by a stored fixed-point reciprocal with 16 fractional bits, rounded up. It shifts the product right by 16, saturates it and restores the sign. While the beats pass through, the block records the index of the highest-numbered nonzero result and whether any result was nonzero. It reports both on the final output beat of the block.

Each block begins with a header beat. The header carries the quantizer scale (1 to 31), the motion-compensated SAD of the block and an inter/intra flag. An inter block whose SAD is below 25 times the scale is predicted to quantize to all zeros. For such a block the 32 coefficient beats are still accepted, but no multiply result is used: every output is zero and the block reports not coded.

Every stream uses valid/ready. A transfer happens on a rising edge where valid and ready are both high.
- The output is a single register stage. While `out_valid` is high and `out_ready` is low, every output holds its value.
- `in_ready` is high only inside a block, and only while the output register is empty or is being drained in the same cycle.
- `hdr_ready` is high only between blocks.

Top module: `qz_block_quant`

## Requirements
- R1: After reset, `out_valid` is 0, `hdr_ready` is 1 and `in_ready` is 0.
- R2: An inter block with SAD < 25 × scale is skipped. All 64 output values are 0, `out_coded` is 0 and `out_last` is 0. A SAD of exactly 25 × scale is not skipped.
- R3: An intra block is never skipped, whatever its SAD.
- R4: Each output equals sign(x) × floor(|x| / scale), that is, the quotient truncated toward zero. Coefficient index 2k travels in bits [11:0] of beat k and index 2k+1 travels in bits [23:12]. Each coefficient is a signed 12-bit two's-complement value.
- R5: Outputs are saturated to the range −2048 to +2047. With scale 1, −2048 gives −2048 and +2047 gives +2047.
- R6: On the final beat, `out_last` is the index (0 to 63) of the highest-numbered nonzero output in the block, or 0 if there is none.
- R7: `out_coded` is 1 only on the final beat, and only if at least one output in the block is nonzero.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and every output stay unchanged on the next cycle.
- R9: Each block gives exactly 32 output beats, and `out_eob` is 1 on the 32nd beat only. Each accepted input beat appears on the output one cycle later. A header is accepted only between blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_valid | input | 1 | Header beat offered |
| hdr_ready | output | 1 | Header can be accepted (between blocks) |
| hdr_qs | input | 5 | Quantizer scale, 1 to 31 |
| hdr_sad | input | 16 | Motion-compensated SAD of the block |
| hdr_inter | input | 1 | 1 = inter block (may be skipped), 0 = intra |
| in_valid | input | 1 | Coefficient pair offered |
| in_ready | output | 1 | Coefficient pair can be accepted |
| in_coef | input | 24 | Even index in [11:0], odd index in [23:12], signed |
| out_valid | output | 1 | Quantized pair available |
| out_ready | input | 1 | Downstream takes the pair |
| out_coef | output | 24 | Quantized pair, same lane order as the input |
| out_eob | output | 1 | Final beat of the block |
| out_last | output | 6 | Highest nonzero index, valid with `out_eob` |
| out_coded | output | 1 | Block has a nonzero output, valid with `out_eob` |

## Verification
Two things can happen in the same cycle on the final input beat. The last pair can update the nonzero-position tracker while that same beat is written into the block report. The bench provokes this with blocks whose only nonzero values sit at index 62 or 63, and compares the reported position with the one it computes. That report beat can also meet a stalled `out_ready`. The bench throttles the output on alternate blocks and checks that the final beat, with its position and coded flag, is held intact until it is taken. SAD values one below and exactly at the skip bound are used for several scales.

// File: rtl/qz_pkg.sv
package qz_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} qz_state_e;

  // ceil(2^frac / q); a zero divisor yields zero
  function automatic int unsigned recip_ceil(int unsigned q, int unsigned frac);
    if (q == 0) return 0;
    return ((32'd1 << frac) + q - 1) / q;
  endfunction

endpackage

// File: rtl/qz_recip_rom.sv
module qz_recip_rom #(
  parameter int QS_W   = 5,
  parameter int FRAC_W = 16
) (
  input  logic [QS_W-1:0]   qs,
  output logic [FRAC_W:0]   recip
);
  localparam int N   = 1 << QS_W;
  localparam int R_W = FRAC_W + 1;

  logic [R_W-1:0] tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign tbl[g] = R_W'(qz_pkg::recip_ceil(g, FRAC_W));
  end

  assign recip = tbl[qs];
endmodule

// File: rtl/qz_lane.sv
module qz_lane #(
  parameter int COEF_W = 12,
  parameter int FRAC_W = 16
) (
  input  logic [COEF_W-1:0] coef,
  input  logic [FRAC_W:0]   recip,
  input  logic              force_zero,
  output logic [COEF_W-1:0] q,
  output logic              nz
);
  localparam int R_W = FRAC_W + 1;
  localparam int P_W = COEF_W + R_W;
  localparam int Q_W = P_W - FRAC_W;
  localparam logic [Q_W-1:0] POS_LIM = Q_W'((1 << (COEF_W-1)) - 1);
  localparam logic [Q_W-1:0] NEG_LIM = Q_W'(1 << (COEF_W-1));

  logic              neg;
  logic [COEF_W-1:0] mag;
  logic [P_W-1:0]    prod;
  logic [Q_W-1:0]    quo, lim, sat;
  logic [COEF_W-1:0] res;

  always_comb begin
    neg  = coef[COEF_W-1];
    mag  = neg ? (~coef + 1'b1) : coef;
    prod = {{R_W{1'b0}}, mag} * {{COEF_W{1'b0}}, recip};
    quo  = prod[P_W-1:FRAC_W];
    lim  = neg ? NEG_LIM : POS_LIM;
    sat  = (quo > lim) ? lim : quo;
    res  = neg ? (~sat[COEF_W-1:0] + 1'b1) : sat[COEF_W-1:0];
    q    = force_zero ? '0 : res;
    nz   = |q;
  end
endmodule

// File: rtl/qz_last_track.sv
module qz_last_track #(
  parameter int LANES = 2,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [IDX_W-1:0] base,
  input  logic [LANES-1:0] nz,
  output logic [IDX_W-1:0] last_next,
  output logic             any_next
);
  logic [IDX_W-1:0] last_q;
  logic             any_q;

  always_comb begin
    last_next = last_q;
    for (int l = 0; l < LANES; l++) begin
      if (nz[l]) last_next = base + IDX_W'(l);
    end
    any_next = any_q | (|nz);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      any_q  <= 1'b0;
    end else if (clear) begin
      last_q <= '0;
      any_q  <= 1'b0;
    end else if (step) begin
      last_q <= last_next;
      any_q  <= any_next;
    end
  end
endmodule

// File: rtl/qz_block_quant.sv
module qz_block_quant #(
  parameter int COEF_W      = 12,
  parameter int QS_W        = 5,
  parameter int SAD_W       = 16,
  parameter int FRAC_W      = 16,
  parameter int SKIP_THRESH = 25,
  parameter int BLK_N       = 64,
  parameter int LANES       = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hdr_valid,
  output logic                    hdr_ready,
  input  logic [QS_W-1:0]         hdr_qs,
  input  logic [SAD_W-1:0]        hdr_sad,
  input  logic                    hdr_inter,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*COEF_W-1:0] in_coef,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*COEF_W-1:0] out_coef,
  output logic                    out_eob,
  output logic [$clog2(BLK_N)-1:0] out_last,
  output logic                    out_coded
);
  import qz_pkg::*;

  localparam int BEATS  = BLK_N / LANES;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int IDX_W  = $clog2(BLK_N);
  localparam int TH_W   = SAD_W + QS_W + 8;

  qz_state_e         state_q;
  logic [QS_W-1:0]   qs_q;
  logic              skip_q;
  logic [BEAT_W-1:0] beat_q;

  logic              hdr_fire, in_fire, final_beat, skip_now;
  logic [TH_W-1:0]   bound;
  logic [IDX_W-1:0]  base, last_next;
  logic              any_next;
  logic [FRAC_W:0]   recip;
  logic [LANES-1:0]  nz;
  logic [LANES*COEF_W-1:0] q_bus;

  assign hdr_ready  = (state_q == ST_IDLE);
  assign in_ready   = (state_q == ST_RUN) && (!out_valid || out_ready);
  assign hdr_fire   = hdr_valid && hdr_ready;
  assign in_fire    = in_valid && in_ready;
  assign final_beat = (beat_q == BEAT_W'(BEATS-1));
  assign bound      = TH_W'(SKIP_THRESH) * TH_W'(hdr_qs);
  assign skip_now   = hdr_inter && (TH_W'(hdr_sad) < bound);
  assign base       = IDX_W'(beat_q) * IDX_W'(LANES);

  qz_recip_rom #(.QS_W(QS_W), .FRAC_W(FRAC_W)) u_rom (
    .qs(qs_q), .recip(recip)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    qz_lane #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_lane (
      .coef      (in_coef[l*COEF_W +: COEF_W]),
      .recip     (recip),
      .force_zero(skip_q),
      .q         (q_bus[l*COEF_W +: COEF_W]),
      .nz        (nz[l])
    );
  end

  qz_last_track #(.LANES(LANES), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(hdr_fire), .step(in_fire),
    .base(base), .nz(nz), .last_next(last_next), .any_next(any_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      qs_q    <= '0;
      skip_q  <= 1'b0;
      beat_q  <= '0;
    end else if (hdr_fire) begin
      state_q <= ST_RUN;
      qs_q    <= hdr_qs;
      skip_q  <= skip_now;
      beat_q  <= '0;
    end else if (in_fire) begin
      beat_q <= beat_q + 1'b1;
      if (final_beat) state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_coef  <= '0;
      out_eob   <= 1'b0;
      out_last  <= '0;
      out_coded <= 1'b0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_coef  <= q_bus;
      out_eob   <= final_beat;
      out_last  <= final_beat ? last_next : '0;
      out_coded <= final_beat && any_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/qz_block_quant_chk.sv
module qz_block_quant_chk #(
  parameter int COEF_W = 12,
  parameter int LANES  = 2,
  parameter int IDX_W  = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    hdr_ready,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*COEF_W-1:0] out_coef,
  input logic                    out_eob,
  input logic [IDX_W-1:0]        out_last,
  input logic                    out_coded,
  input logic                    skip_q
);
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_coef) && $stable(out_eob)
      && $stable(out_last) && $stable(out_coded));

  a_r2_skip_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && skip_q |=> out_coef == '0 && !out_coded);

  a_r6_uncoded_last_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_coded |-> out_last == '0);

  a_r7_coded_on_eob: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_coded |-> out_eob);

  a_r9_beat_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r9_no_hdr_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> !hdr_ready);
endmodule

bind qz_block_quant qz_block_quant_chk #(
  .COEF_W(COEF_W), .LANES(LANES), .IDX_W($clog2(BLK_N))
) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_ready(hdr_ready), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_coef(out_coef), .out_eob(out_eob), .out_last(out_last),
  .out_coded(out_coded), .skip_q(skip_q)
);

// File: tb/test_qz_block_quant.sv
module test_qz_block_quant;
  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [4:0]  hdr_qs = '0;
  logic [15:0] hdr_sad = '0;
  logic        hdr_inter = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_coef = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_coef;
  logic        out_eob;
  logic [5:0]  out_last;
  logic        out_coded;

  int checks = 0;
  int fails  = 0;

  int cf [64];
  int ex [64];

  always #(CLK_P/2) clk = ~clk;

  qz_block_quant i_qz_block_quant (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_qs(hdr_qs), .hdr_sad(hdr_sad), .hdr_inter(hdr_inter),
    .in_valid(in_valid), .in_ready(in_ready), .in_coef(in_coef),
    .out_valid(out_valid), .out_ready(out_ready), .out_coef(out_coef),
    .out_eob(out_eob), .out_last(out_last), .out_coded(out_coded)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int quant(int x, int q);
    int m, r;
    m = (x < 0) ? -x : x;
    r = m / q;
    if (x < 0) return (r > 2048) ? -2048 : -r;
    return (r > 2047) ? 2047 : r;
  endfunction

  function automatic int lane_val(logic [23:0] bus, int l);
    logic [11:0] v;
    v = bus[l*12 +: 12];
    return int'($signed(v));
  endfunction

  task automatic drive(input int qs, input int sad, input bit inter);
    bit ok;
    @(negedge clk);
    hdr_valid = 1'b1; hdr_qs = 5'(qs); hdr_sad = 16'(sad); hdr_inter = inter;
    while (1) begin
      #(CLK_P/2-1); ok = hdr_ready; @(negedge clk);
      if (ok) break;
    end
    hdr_valid = 1'b0;
    for (int b = 0; b < 32; b++) begin
      in_valid = 1'b1;
      in_coef  = {12'(cf[2*b+1]), 12'(cf[2*b])};
      while (1) begin
        #(CLK_P/2-1); ok = in_ready; @(negedge clk);
        if (ok) break;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic collect(input bit stall, input string req, input int elast,
                         input bit ecoded);
    int k = 0;
    int cyc = 0;
    bit held = 1'b0;
    logic [23:0] h_coef;
    logic h_eob, h_coded;
    logic [5:0] h_last;
    while (k < 32) begin
      @(negedge clk);
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
      #(CLK_P/2-1);
      if (held) begin
        chk(out_valid && out_coef == h_coef && out_eob == h_eob &&
            out_last == h_last && out_coded == h_coded,
            "R8", "stalled beat held", int'(out_coef), int'(h_coef));
      end
      held = 1'b0;
      if (out_valid && out_ready) begin
        for (int l = 0; l < 2; l++)
          chk(lane_val(out_coef, l) == ex[2*k+l], req, "coef value",
              lane_val(out_coef, l), ex[2*k+l]);
        chk(out_eob == (k == 31), "R9", "eob flag", int'(out_eob), int'(k == 31));
        if (k == 31) begin
          chk(out_last == 6'(elast), "R6", "last position", int'(out_last), elast);
          chk(out_coded == ecoded, "R7", "coded flag", int'(out_coded), int'(ecoded));
        end else begin
          chk(out_coded == 1'b0, "R7", "coded before eob", int'(out_coded), 0);
        end
        k++;
      end else if (out_valid) begin
        held = 1'b1; h_coef = out_coef; h_eob = out_eob;
        h_last = out_last; h_coded = out_coded;
      end
    end
  endtask

  task automatic run_block(input int qs, input int sad, input bit inter,
                           input bit stall, input string req);
    bit skip;
    int elast = 0;
    bit ecoded = 1'b0;
    skip = inter && (sad < 25 * qs);
    for (int i = 0; i < 64; i++) begin
      ex[i] = skip ? 0 : quant(cf[i], qs);
      if (ex[i] != 0) begin elast = i; ecoded = 1'b1; end
    end
    fork
      drive(qs, sad, inter);
      collect(stall, req, elast, ecoded);
    join
    #(CLK_P/2-1);
    chk(hdr_ready == 1'b1, "R9", "header ready between blocks", int'(hdr_ready), 1);
  endtask

  task automatic fill(input int seed, input int lim);
    for (int i = 0; i < 64; i++)
      cf[i] = (i > lim) ? 0 : (((i * 37 + seed * 101 + 13) % 4096) - 2048);
  endtask

  task automatic clear_cf();
    for (int i = 0; i < 64; i++) cf[i] = 0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d cycles", WD_CYCLES, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(hdr_ready == 1'b1, "R1", "hdr_ready in reset", int'(hdr_ready), 1);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0 && hdr_ready && !in_ready, "R1", "idle after reset",
        int'(out_valid), 0);

    // R4 sweep over every scale, varying tail length, alternate stalls
    for (int q = 1; q < 32; q++) begin
      fill(q, (q * 13) % 64);
      run_block(q, 0, 1'b0, q[0], "R4");
    end

    // R5 extremes with scale 1
    for (int i = 0; i < 64; i++) cf[i] = (i % 2 == 0) ? -2048 : 2047;
    run_block(1, 0, 1'b0, 1'b1, "R5");

    // R7 everything quantizes to zero
    for (int i = 0; i < 64; i++) cf[i] = (i % 61) - 30;
    run_block(31, 0, 1'b0, 1'b0, "R7");

    // R6 last position corners
    clear_cf(); cf[0] = 500;
    run_block(4, 0, 1'b0, 1'b0, "R6");
    clear_cf(); cf[62] = -700;
    run_block(5, 0, 1'b0, 1'b1, "R6");
    clear_cf(); cf[63] = 9; cf[10] = 100;
    run_block(3, 0, 1'b0, 1'b1, "R6");
    clear_cf(); cf[62] = 40; cf[63] = 7;
    run_block(8, 0, 1'b0, 1'b0, "R6");

    // R2 skip bound, R3 intra never skipped
    for (int s = 0; s < 3; s++) begin
      int q;
      q = (s == 0) ? 1 : ((s == 1) ? 7 : 31);
      fill(q + 50, 63);
      run_block(q, 25 * q - 1, 1'b1, s[0], "R2");
      run_block(q, 25 * q, 1'b1, 1'b0, "R2");
      run_block(q, 0, 1'b0, 1'b1, "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule